// File: doc/BRIEF.md
# Host-Target Command Mailbox

This block is a small mailbox through which a processor talks to a host-side agent. It holds two 64-bit registers, an outbound command word and an inbound response word. Each register is reached over a 32-bit register bus as a low half and a high half. Software fills the command word low half first, then high half. The write to the high half commits the command. The block then decodes the command at once and acts on it.

Two services sit behind the command word. The first is a test-completion service that raises an exit strobe carrying a result code. The second is a character console. It sends bytes out on a transmit strobe and accepts bytes from a receive strobe. After each command the block clears the command word, which tells software the command was taken. Most commands also put an echo of the command's top 16 bits, together with a response value, into the response word. A console read request is stored instead, and its top bits tag the characters that arrive later.

Top module: `hostlink_mailbox`

## Requirements
- R1: Reset clears both 64-bit registers, the stored read request and the commit-enable flag. After reset all four bus words read zero, tx_valid and exit_valid are low, and a high-half command write made with no prior low-half write has no effect.
- R2: Word addresses are fixed as follows: TO_OFS holds command bits 31:0 and TO_OFS+4 holds bits 63:32; FROM_OFS holds response bits 31:0 and FROM_OFS+4 holds bits 63:32. Any other address reads zero, and writes to it change nothing.
- R3: A low-half command write is accepted only while the command word is zero. When accepted, it loads bits 31:0, clears bits 63:32 and sets the commit-enable flag. When rejected, the command word is unchanged and the flag is cleared, so the next high-half write is ignored.
- R4: A high-half command write made while the commit-enable flag is set ORs the data into bits 63:32. The resulting word is decoded as device = bits 63:56, command = bits 55:48 and payload = bits 47:0. The command word reads zero on the next cycle.
- R5: Device 0x00 with command 0x00 and payload bit 0 set raises exit_valid for one cycle, with exit_code = payload bits 47:1. The response word becomes {bits 63:48, 48'h0}.
- R6: Device 0x01 with command 0x01 raises tx_valid for one cycle, with tx_data = payload bits 7:0. The response word becomes {bits 63:48, 48'h100 | character}.
- R7: Device 0x01 with command 0x00 stores the command's top 16 bits as the read request and clears the command word. The response word is left unchanged and no strobe is raised.
- R8: Every other device and command combination sets the response word to {bits 63:48, 48'h0}. This includes device 0 command 0 with payload bit 0 clear. No strobe is raised.
- R9: A byte with rx_valid high sets the response word on the next cycle to {stored request bits, 48'h100 | byte}. This overwrites any unread value.
- R10: A received byte is dropped if, in the same cycle, a bus write goes to either response half or a committed command is handled.
- R11: A bus write to the response low half loads bits 31:0 and clears bits 63:32. A write to the response high half ORs its data into bits 63:32.
- R12: The commit-enable flag stays set after a command is handled. A further high-half write with no new low-half write is therefore handled as a command whose low half is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high with bus_sel |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr, combinational |
| tx_valid | output | 1 | One-cycle strobe for an outgoing console byte |
| tx_data | output | 8 | Outgoing console byte |
| rx_valid | input | 1 | Incoming console byte strobe |
| rx_data | input | 8 | Incoming console byte |
| exit_valid | output | 1 | One-cycle test-completion strobe |
| exit_code | output | 47 | Test result code |

## Verification
The bench builds the block with ADDR_W = 5 and the default offsets 0x0 and 0x8. This leaves the upper half of the address space, from 0x10 to 0x1C, unmapped, so reads and writes to addresses that match no register can be tried without any aliasing onto the mapped words. With 32-bit words, the split-word commit and the OR-merge of the high half can be tried with payloads that span both halves. Exit codes are chosen to cross the half boundary.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

   localparam int unsigned HL_PAY_W  = 48;
   localparam int unsigned HL_CHAR_W = 8;
   localparam int unsigned HL_CODE_W = HL_PAY_W - 1;
   localparam int unsigned HL_TAG_W  = 16;

   localparam logic [7:0] HL_DEV_EXIT  = 8'h00;
   localparam logic [7:0] HL_DEV_CONS  = 8'h01;
   localparam logic [7:0] HL_CMD_EXIT  = 8'h00;
   localparam logic [7:0] HL_CMD_READ  = 8'h00;
   localparam logic [7:0] HL_CMD_WRITE = 8'h01;

   typedef struct packed {
      logic [7:0]          dev;
      logic [7:0]          cmd;
      logic [HL_PAY_W-1:0] payload;
   } hl_cmd_t;

   typedef enum logic [1:0] {
      HL_ACT_NONE,
      HL_ACT_EXIT,
      HL_ACT_PUTC,
      HL_ACT_READ
   } hl_act_e;

endpackage

// File: rtl/hostlink_cmd_decode.sv
module hostlink_cmd_decode
   import hostlink_pkg::*;
(
   input  logic [7:0]           dev_i,
   input  logic [7:0]           cmd_i,
   input  logic [HL_CHAR_W-1:0] chr_i,
   output hl_act_e              act_o,
   output logic [HL_PAY_W-1:0]  resp_o
);

   always_comb begin
      act_o  = HL_ACT_NONE;
      resp_o = '0;
      if (dev_i == HL_DEV_EXIT) begin
         if (cmd_i == HL_CMD_EXIT && chr_i[0]) begin
            act_o = HL_ACT_EXIT;
         end
      end else if (dev_i == HL_DEV_CONS) begin
         if (cmd_i == HL_CMD_WRITE) begin
            act_o  = HL_ACT_PUTC;
            resp_o = {{(HL_PAY_W-HL_CHAR_W-1){1'b0}}, 1'b1, chr_i};
         end else if (cmd_i == HL_CMD_READ) begin
            act_o = HL_ACT_READ;
         end
      end
   end

endmodule

// File: rtl/hostlink_bus_decode.sv
module hostlink_bus_decode #(
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TO_OFS   = 0,
   parameter int unsigned FROM_OFS = 8
) (
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [2*BUS_W-1:0]   tohost_i,
   input  logic [2*BUS_W-1:0]   fromhost_i,
   output logic [3:0]           wr_o,
   output logic [BUS_W-1:0]     rdata_o
);

   localparam int unsigned NSLOT  = 4;
   localparam int unsigned WBYTES = BUS_W / 8;

   logic [NSLOT-1:0]            hit;
   logic [NSLOT-1:0][BUS_W-1:0] slot_data;

   assign slot_data[0] = tohost_i[BUS_W-1:0];
   assign slot_data[1] = tohost_i[2*BUS_W-1:BUS_W];
   assign slot_data[2] = fromhost_i[BUS_W-1:0];
   assign slot_data[3] = fromhost_i[2*BUS_W-1:BUS_W];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam int unsigned BASE = (s < 2) ? TO_OFS : FROM_OFS;
      localparam int unsigned OFS  = BASE + (s % 2) * WBYTES;
      assign hit[s] = (bus_addr == ADDR_W'(OFS));
   end

   always_comb begin
      rdata_o = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (hit[s]) rdata_o = rdata_o | slot_data[s];
      end
   end

   assign wr_o = {NSLOT{bus_sel & bus_we}} & hit;

endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox
   import hostlink_pkg::*;
#(
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TO_OFS   = 0,
   parameter int unsigned FROM_OFS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic                 tx_valid,
   output logic [HL_CHAR_W-1:0] tx_data,
   input  logic                 rx_valid,
   input  logic [HL_CHAR_W-1:0] rx_data,
   output logic                 exit_valid,
   output logic [HL_CODE_W-1:0] exit_code
);

   localparam int unsigned WORD_W = 2 * BUS_W;

   // elaboration-time parameter checks
   if (BUS_W != 32) begin : g_bad_bus
      $error("hostlink_mailbox: BUS_W must be 32");
   end
   if ((TO_OFS % 8) != 0 || (FROM_OFS % 8) != 0) begin : g_bad_align
      $error("hostlink_mailbox: register offsets must be 8-byte aligned");
   end
   if (TO_OFS == FROM_OFS) begin : g_bad_overlap
      $error("hostlink_mailbox: register offsets must differ");
   end
   if (TO_OFS + 8 > (1 << ADDR_W) || FROM_OFS + 8 > (1 << ADDR_W)) begin : g_bad_span
      $error("hostlink_mailbox: ADDR_W too small for the offsets");
   end

   logic [WORD_W-1:0]   tohost_q;
   logic [WORD_W-1:0]   fromhost_q;
   logic [HL_TAG_W-1:0] pend_q;
   logic                accept_q;
   logic [3:0]          wr;
   hl_cmd_t             cmd_full;
   hl_act_e             act;
   logic [HL_PAY_W-1:0] resp;
   logic                run_cmd;

   hostlink_bus_decode #(
      .BUS_W   (BUS_W),
      .ADDR_W  (ADDR_W),
      .TO_OFS  (TO_OFS),
      .FROM_OFS(FROM_OFS)
   ) u_bus (
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .tohost_i  (tohost_q),
      .fromhost_i(fromhost_q),
      .wr_o      (wr),
      .rdata_o   (bus_rdata)
   );

   assign cmd_full = hl_cmd_t'(tohost_q | {bus_wdata, {BUS_W{1'b0}}});
   assign run_cmd  = wr[1] & accept_q;

   hostlink_cmd_decode u_dec (
      .dev_i (cmd_full.dev),
      .cmd_i (cmd_full.cmd),
      .chr_i (cmd_full.payload[HL_CHAR_W-1:0]),
      .act_o (act),
      .resp_o(resp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tohost_q   <= '0;
         fromhost_q <= '0;
         pend_q     <= '0;
         accept_q   <= 1'b0;
         tx_valid   <= 1'b0;
         tx_data    <= '0;
         exit_valid <= 1'b0;
         exit_code  <= '0;
      end else begin
         tx_valid   <= 1'b0;
         exit_valid <= 1'b0;

         if (wr[0]) begin
            if (tohost_q == '0) begin
               accept_q <= 1'b1;
               tohost_q <= {{BUS_W{1'b0}}, bus_wdata};
            end else begin
               accept_q <= 1'b0;
            end
         end

         if (run_cmd) begin
            tohost_q <= '0;
            if (act == HL_ACT_READ) begin
               pend_q <= {cmd_full.dev, cmd_full.cmd};
            end else begin
               fromhost_q <= {cmd_full.dev, cmd_full.cmd, resp};
            end
            if (act == HL_ACT_PUTC) begin
               tx_valid <= 1'b1;
               tx_data  <= cmd_full.payload[HL_CHAR_W-1:0];
            end
            if (act == HL_ACT_EXIT) begin
               exit_valid <= 1'b1;
               exit_code  <= cmd_full.payload[HL_PAY_W-1:1];
            end
         end else if (wr[2]) begin
            fromhost_q <= {{BUS_W{1'b0}}, bus_wdata};
         end else if (wr[3]) begin
            fromhost_q <= fromhost_q | {bus_wdata, {BUS_W{1'b0}}};
         end else if (rx_valid) begin
            fromhost_q <= {pend_q, {(HL_PAY_W-HL_CHAR_W-1){1'b0}}, 1'b1, rx_data};
         end
      end
   end

endmodule

// File: rtl/hostlink_mailbox_chk.sv
module hostlink_mailbox_chk #(
   parameter int unsigned BUS_W    = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned TO_OFS   = 0,
   parameter int unsigned FROM_OFS = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               rx_valid,
   input logic [7:0]         rx_data,
   input logic               tx_valid,
   input logic               exit_valid,
   input logic [2*BUS_W-1:0] tohost_q,
   input logic [2*BUS_W-1:0] fromhost_q,
   input logic [15:0]        pend_q,
   input logic               accept_q
);

   localparam logic [ADDR_W-1:0] A_TO_LO   = ADDR_W'(TO_OFS);
   localparam logic [ADDR_W-1:0] A_TO_HI   = ADDR_W'(TO_OFS + 4);
   localparam logic [ADDR_W-1:0] A_FROM_LO = ADDR_W'(FROM_OFS);
   localparam logic [ADDR_W-1:0] A_FROM_HI = ADDR_W'(FROM_OFS + 4);

   logic wr_any, lo_wr, hi_commit, from_wr;
   assign wr_any    = bus_sel && bus_we;
   assign lo_wr     = wr_any && bus_addr == A_TO_LO;
   assign hi_commit = wr_any && bus_addr == A_TO_HI && accept_q;
   assign from_wr   = wr_any && (bus_addr == A_FROM_LO || bus_addr == A_FROM_HI);

   AST_LOW_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && tohost_q != '0) |=> (tohost_q == $past(tohost_q))); // R3

   AST_ACCEPT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      accept_q |-> (tohost_q[2*BUS_W-1:BUS_W] == '0)); // R3

   AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hi_commit |=> (tohost_q == '0)); // R4

   AST_TX_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(hi_commit)); // R6

   AST_EXIT_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      exit_valid |-> $past(hi_commit)); // R5

   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid && exit_valid)); // R8

   AST_RX_LOADS_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !from_wr && !hi_commit) |=>
      (fromhost_q == {$past(pend_q), 39'd0, 1'b1, $past(rx_data)})); // R9

endmodule

bind hostlink_mailbox hostlink_mailbox_chk #(
   .BUS_W   (BUS_W),
   .ADDR_W  (ADDR_W),
   .TO_OFS  (TO_OFS),
   .FROM_OFS(FROM_OFS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .tx_valid  (tx_valid),
   .exit_valid(exit_valid),
   .tohost_q  (tohost_q),
   .fromhost_q(fromhost_q),
   .pend_q    (pend_q),
   .accept_q  (accept_q)
);

// File: tb/hostlink_mailbox_bench.sv
module hostlink_mailbox_bench;

   localparam int AW = 5;
   localparam logic [AW-1:0] TL = 5'h00, TH = 5'h04, FL = 5'h08, FH = 5'h0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        tx_valid, exit_valid;
   logic [7:0]  tx_data;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [46:0] exit_code;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   hostlink_mailbox #(.ADDR_W(AW)) u_hostlink_mailbox (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
      .rx_data(rx_data), .exit_valid(exit_valid), .exit_code(exit_code)
   );

   typedef struct packed {
      logic [31:0] lo;
      logic [31:0] hi;
      logic [63:0] from;
      logic        txv;
      logic [7:0]  txd;
      logic        exv;
      logic [46:0] exc;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'h0000_0041, 32'h0101_0000, 64'h0101_0000_0000_0141, 1'b1, 8'h41, 1'b0, 47'h0},
      '{32'h0000_0040, 32'h0000_0000, 64'h0000_0000_0000_0000, 1'b0, 8'h00, 1'b0, 47'h0},
      '{32'h1234_56FF, 32'h0101_ABCD, 64'h0101_0000_0000_01FF, 1'b1, 8'hFF, 1'b0, 47'h0},
      '{32'h0000_002B, 32'h0000_0003, 64'h0000_0000_0000_0000, 1'b0, 8'h00, 1'b1, 47'h1_8000_0015},
      '{32'h0000_0001, 32'h0005_0000, 64'h0005_0000_0000_0000, 1'b0, 8'h00, 1'b0, 47'h0},
      '{32'h0000_0041, 32'h0701_0000, 64'h0701_0000_0000_0000, 1'b0, 8'h00, 1'b0, 47'h0},
      '{32'h0000_0041, 32'h0102_0000, 64'h0102_0000_0000_0000, 1'b0, 8'h00, 1'b0, 47'h0},
      '{32'h0000_0000, 32'h0001_0000, 64'h0001_0000_0000_0000, 1'b0, 8'h00, 1'b0, 47'h0}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic write_with_rx(input logic [AW-1:0] a, input logic [31:0] d, input logic [7:0] c);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      rx_valid = 1'b1; rx_data = c;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic check_word(input string req, input logic [AW-1:0] base, input logic [63:0] exp);
      logic [31:0] lo, hi;
      rd(base, lo);
      rd(base + 5'd4, hi);
      check(req, {hi, lo}, exp);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 tx_valid after reset", 64'(tx_valid), 64'h0);
      check("R1 exit_valid after reset", 64'(exit_valid), 64'h0);
      check_word("R1 command word after reset", TL, 64'h0);
      check_word("R1 response word after reset", FL, 64'h0);

      // table walk: R4 R5 R6 R8
      for (int i = 0; i < 8; i++) begin
         bus_write(TL, VECS[i].lo);
         check_word("R3 low half loaded", TL, {32'h0, VECS[i].lo});
         bus_write(TH, VECS[i].hi);
         check("R6 tx_valid", 64'(tx_valid), 64'(VECS[i].txv));
         if (VECS[i].txv) check("R6 tx_data", 64'(tx_data), 64'(VECS[i].txd));
         check("R5 exit_valid", 64'(exit_valid), 64'(VECS[i].exv));
         if (VECS[i].exv) check("R5 exit_code", 64'(exit_code), 64'(VECS[i].exc));
         check_word("R8 response word", FL, VECS[i].from);
         check_word("R4 command word cleared", TL, 64'h0);
      end

      // R2: unmapped addresses
      rd(5'h10, r); check("R2 read 0x10", 64'(r), 64'h0);
      rd(5'h14, r); check("R2 read 0x14", 64'(r), 64'h0);
      rd(5'h02, r); check("R2 read 0x02", 64'(r), 64'h0);
      bus_write(5'h18, 32'hFFFF_FFFF);
      check_word("R2 response untouched by unmapped write", FL, 64'h0001_0000_0000_0000);
      check_word("R2 command untouched by unmapped write", TL, 64'h0);

      // R7: console read request
      bus_write(TL, 32'h0000_0000);
      bus_write(TH, 32'h0100_0000);
      check("R7 no tx on read request", 64'(tx_valid), 64'h0);
      check_word("R7 response unchanged", FL, 64'h0001_0000_0000_0000);
      check_word("R7 command word cleared", TL, 64'h0);

      // R9: incoming characters, overwrite
      rx_byte(8'h5A);
      check_word("R9 first rx", FL, 64'h0100_0000_0000_015A);
      rx_byte(8'h33);
      check_word("R9 rx overwrite", FL, 64'h0100_0000_0000_0133);

      // R10: rx dropped on a colliding write
      write_with_rx(FL, 32'h0000_0077, 8'h99);
      check_word("R10 rx dropped on response write", FL, 64'h0000_0000_0000_0077);
      bus_write(TL, 32'h0000_0042);
      write_with_rx(TH, 32'h0101_0000, 8'h11);
      check("R10 tx during rx collision", 64'(tx_data), 64'h42);
      check_word("R10 rx dropped on command", FL, 64'h0101_0000_0000_0142);

      // R12: repeated high write without new low half
      bus_write(TH, 32'h0101_0000);
      check("R12 tx_valid on repeat", 64'(tx_valid), 64'h1);
      check("R12 tx_data on repeat", 64'(tx_data), 64'h0);
      check_word("R12 response on repeat", FL, 64'h0101_0000_0000_0100);

      // R11: software writes to response word
      bus_write(FL, 32'hDEAD_BEEF);
      check_word("R11 low write clears upper", FL, 64'h0000_0000_DEAD_BEEF);
      bus_write(FH, 32'h1234_5678);
      check_word("R11 high write", FL, 64'h1234_5678_DEAD_BEEF);
      bus_write(FH, 32'h8000_0000);
      check_word("R11 high write ORs", FL, 64'h9234_5678_DEAD_BEEF);
      bus_write(FL, 32'h0000_0001);
      check_word("R11 second low write", FL, 64'h0000_0000_0000_0001);

      // R3: rejected low write disarms the high write
      bus_write(TL, 32'h0000_0011);
      bus_write(TL, 32'h0000_0022);
      check_word("R3 rejected low write", TL, 64'h0000_0000_0000_0011);
      bus_write(TH, 32'h0101_0000);
      check("R3 disarmed high write no tx", 64'(tx_valid), 64'h0);
      check_word("R3 disarmed high write", TL, 64'h0000_0000_0000_0011);
      check_word("R3 response kept", FL, 64'h0000_0000_0000_0001);

      // R1: reset clears everything including flag and request
      apply_reset();
      check_word("R1 command cleared by reset", TL, 64'h0);
      check_word("R1 response cleared by reset", FL, 64'h0);
      check("R1 exit_code after reset", 64'(exit_code), 64'h0);
      bus_write(TH, 32'h0101_0000);
      check("R1 flag cleared by reset", 64'(tx_valid), 64'h0);
      check_word("R1 no response without flag", FL, 64'h0);
      rx_byte(8'h20);
      check_word("R1 request cleared by reset", FL, 64'h0000_0000_0000_0120);

      done = 1'b1;
      report();
      $finish;
   end

endmodule